// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a bank of SDR SDRAM rows from power-on to normal operation without software help. One pulse on `start` runs the whole bring-up. The block waits for supply and clock to settle, then issues NOP, precharge-all, a fixed number of auto-refresh rounds and a mode-register-set. Each command has its own programmable wait in clock cycles. The block then returns the command selection to normal, and only after that does it switch refresh on and raise `done`.

Every command except normal goes to the populated rows one at a time, one row per clock, in ascending row order. The block works out which rows are populated from their end boundaries and skips the empty ones. The mode word placed on the address pins during mode-register-set is built from a CAS-latency selector. `start` latches the row boundaries and the latency choice.

Top module: `sdram_init_seq`

## Requirements
- R1: `cmd_sel` carries the current step as a 3-bit code: 0 normal, 1 NOP, 2 precharge-all, 3 mode-register-set, 4 auto-refresh. It never shows 5, 6 or 7. It reads 0 while idle, during the settle wait and after completion.
- R2: Taking the cycle after the `start` edge as cycle 0, cycles 0 to T_PWR-1 are the settle wait, with T_PWR = STABLE_US*CLK_MHZ. The steps follow in this order: NOP, then wait T_PWR; precharge-all, then wait T_RP; auto-refresh, then wait T_RC; mode-register-set, then wait T_MRD. Each issue phase takes one cycle per populated row.
- R3: The auto-refresh step with its wait repeats exactly REFRESH_ROUNDS times (8 by default).
- R4: In each issue phase, every populated row gets exactly one command cycle, in ascending row order. In that cycle its `cs_n` bit is low, and no more than one `cs_n` bit is ever low at a time.
- R5: The boundary of row i is `row_bound[8i+7:8i]`. Row i is populated only when its boundary is strictly greater than the boundary of row i-1, with 0 used in place of row -1. Rows that fail this test never see a command.
- R6: The command pins {ras_n,cas_n,we_n} are 111 for NOP, 010 for precharge-all, 001 for auto-refresh and 000 for mode-register-set. They are 111 in every cycle in which no row is selected.
- R7: During mode-register-set cycles, `mode_addr` is 12'h03A when `cl3_sel`=1 (CAS 3, interleaved, burst field 010) and 12'h02A when `cl3_sel`=0 (CAS 2).
- R8: In the cycle after the mode-register-set wait, `cmd_sel` is 0 and `refresh_en` is still 0. In the next cycle `refresh_en` and `done` go to 1. `refresh_en` is 0 throughout the sequence.
- R9: A `start` that arrives while the sequence runs, or after it has finished, has no effect. `done` stays 1 until reset.
- R10: After reset `done`=0, `refresh_en`=0, `busy`=0, `cmd_sel`=0 and all `cs_n` bits are 1.
- R11: With no populated row, no command is driven, but the sequence still runs all its waits and completes on the same schedule with zero issue cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins the sequence from idle |
| cl3_sel | input | 1 | 1 selects CAS latency 3, 0 selects CAS latency 2 |
| row_bound | input | NUM_ROWS*BOUND_W | Cumulative end boundary of each row |
| cmd_sel | output | 3 | Current command selection code |
| cs_n | output | NUM_ROWS | Active-low per-row chip select |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| mode_addr | output | 12 | Mode word on the address pins during mode-register-set |
| busy | output | 1 | Sequence in progress |
| refresh_en | output | 1 | Refresh enable, set only at the end |
| done | output | 1 | Sequence complete, held until reset |

## Verification
Two things meet in the same cycle here. One is the last row-issue cycle of a step, which is also the cycle that loads that step's wait timer. The other is the end of a wait, which chooses the next command and starts it in the following cycle. The bench tests this with row patterns whose populated rows sit at the ends of the array or are scattered across it, and with one pattern that has no populated row at all, so that each wait follows straight on from the one before. Each selected row is compared against a schedule the bench computes, matching cycle number, row, pins and selection code, so one cycle too many or too few at any handover shows up as a mismatch.

// File: rtl/sdram_init_pkg.sv
// Shared types for the SDRAM bring-up sequencer.
// Assumes the 3-bit command code is decoded by a neighbour, so values are fixed.
package sdram_init_pkg;

    typedef enum logic [2:0] {
        CMD_NORMAL    = 3'd0,
        CMD_NOP       = 3'd1,
        CMD_PRECHARGE = 3'd2,
        CMD_MRS       = 3'd3,
        CMD_REFRESH   = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_ISSUE,
        PH_WAIT,
        PH_NORMAL,
        PH_DONE
    } phase_e;

    // Pin pattern {ras_n, cas_n, we_n} for a command.
    function automatic logic [2:0] cmd_pins(cmd_e c);
        case (c)
            CMD_PRECHARGE: return 3'b010;
            CMD_REFRESH:   return 3'b001;
            CMD_MRS:       return 3'b000;
            default:       return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/sdram_row_detect.sv
// Marks each row populated when its end boundary exceeds the one below it.
// Assumes boundaries are cumulative; the boundary below row 0 is zero.
module sdram_row_detect #(
    parameter int NUM_ROWS = 8,
    parameter int BOUND_W  = 8
) (
    input  logic [NUM_ROWS*BOUND_W-1:0] bounds,
    output logic [NUM_ROWS-1:0]         populated
);
    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
        if (i == 0) begin : g_first
            // Compare the first row against an empty base.
            assign populated[i] = bounds[BOUND_W-1:0] != '0;
        end else begin : g_rest
            // Compare the row against its lower neighbour.
            assign populated[i] = bounds[i*BOUND_W +: BOUND_W] > bounds[(i-1)*BOUND_W +: BOUND_W];
        end
    end
endmodule

// File: rtl/sdram_row_pick.sv
// Picks the lowest-numbered row still waiting for the current command.
// Assumes pending may be empty, in which case nothing is picked.
module sdram_row_pick #(
    parameter int NUM_ROWS = 8
) (
    input  logic [NUM_ROWS-1:0] pending,
    output logic [NUM_ROWS-1:0] pick
);
    logic [NUM_ROWS:0] below;
    assign below[0] = 1'b0;
    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_pick
        // A row wins when no lower row is pending.
        assign pick[i]      = pending[i] & ~below[i];
        assign below[i + 1] = below[i] | pending[i];
    end
endmodule

// File: rtl/sdram_wait_timer.sv
// Down-counter for step waits; reports zero when the wait has run out.
// Assumes load carries the wait length minus one.
module sdram_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    // Load on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = cnt == '0;
endmodule

// File: rtl/sdram_init_seq.sv
// SDRAM power-up sequencer: settle wait, NOP, precharge-all, refresh rounds,
// mode-register-set, normal, then refresh enable. Commands go one row per
// cycle to populated rows only. Assumes all wait parameters are at least 1.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int NUM_ROWS       = 8,
    parameter int BOUND_W        = 8,
    parameter int CLK_MHZ        = 100,
    parameter int STABLE_US      = 200,
    parameter int T_RP           = 3,
    parameter int T_RC           = 7,
    parameter int T_MRD          = 2,
    parameter int REFRESH_ROUNDS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        cl3_sel,
    input  logic [NUM_ROWS*BOUND_W-1:0] row_bound,
    output logic [2:0]                  cmd_sel,
    output logic [NUM_ROWS-1:0]         cs_n,
    output logic                        ras_n,
    output logic                        cas_n,
    output logic                        we_n,
    output logic [11:0]                 mode_addr,
    output logic                        busy,
    output logic                        refresh_en,
    output logic                        done
);
    localparam int T_PWR  = STABLE_US * CLK_MHZ;
    localparam int T_M1   = (T_PWR > T_RP) ? T_PWR : T_RP;
    localparam int T_M2   = (T_M1 > T_RC) ? T_M1 : T_RC;
    localparam int T_MAX  = (T_M2 > T_MRD) ? T_M2 : T_MRD;
    localparam int CW     = $clog2(T_MAX + 1);
    localparam int RCW    = $clog2(REFRESH_ROUNDS + 1);
    localparam logic [2:0] BURST_LEN  = 3'b010;
    localparam logic       BURST_INTL = 1'b1;

    phase_e               phase;
    cmd_e                 cur_cmd, go_cmd;
    logic [NUM_ROWS-1:0]  pop_now, pop_q, pending, pick;
    logic [RCW-1:0]       ref_cnt;
    logic                 cl3_q, refresh_q, tmr_zero, tmr_load, step_go, accept, last_row;
    logic [CW-1:0]        tmr_val;

    sdram_row_detect #(.NUM_ROWS(NUM_ROWS), .BOUND_W(BOUND_W)) u_detect (
        .bounds(row_bound), .populated(pop_now));

    sdram_row_pick #(.NUM_ROWS(NUM_ROWS)) u_pick (.pending(pending), .pick(pick));

    sdram_wait_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

    // Wait length minus one for the step that follows a command.
    function automatic logic [CW-1:0] wait_m1(cmd_e c);
        case (c)
            CMD_NOP:       return CW'(T_PWR - 1);
            CMD_PRECHARGE: return CW'(T_RP - 1);
            CMD_REFRESH:   return CW'(T_RC - 1);
            default:       return CW'(T_MRD - 1);
        endcase
    endfunction

    assign accept   = start && phase == PH_IDLE;
    assign step_go  = tmr_zero && (phase == PH_SETTLE || phase == PH_WAIT);
    assign last_row = phase == PH_ISSUE && (pending & ~pick) == '0;

    // Choose the command that follows the wait that is ending.
    always_comb begin
        go_cmd = CMD_NORMAL;
        if (phase == PH_SETTLE) go_cmd = CMD_NOP;
        else case (cur_cmd)
            CMD_NOP:       go_cmd = CMD_PRECHARGE;
            CMD_PRECHARGE: go_cmd = CMD_REFRESH;
            CMD_REFRESH:   go_cmd = (ref_cnt == RCW'(REFRESH_ROUNDS - 1)) ? CMD_MRS : CMD_REFRESH;
            default:       go_cmd = CMD_NORMAL;
        endcase
    end

    // Decide when and with what the wait timer is loaded.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (accept) begin
            tmr_load = 1'b1;
            tmr_val  = CW'(T_PWR - 1);
        end else if (step_go && go_cmd != CMD_NORMAL && pop_q == '0) begin
            tmr_load = 1'b1;
            tmr_val  = wait_m1(go_cmd);
        end else if (last_row) begin
            tmr_load = 1'b1;
            tmr_val  = wait_m1(cur_cmd);
        end
    end

    // Step through the phases and track rows still owed the current command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cur_cmd   <= CMD_NORMAL;
            pop_q     <= '0;
            pending   <= '0;
            ref_cnt   <= '0;
            cl3_q     <= 1'b0;
            refresh_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (accept) begin
                    phase   <= PH_SETTLE;
                    pop_q   <= pop_now;
                    cl3_q   <= cl3_sel;
                    ref_cnt <= '0;
                end
                PH_SETTLE, PH_WAIT: if (step_go) begin
                    if (phase == PH_WAIT && cur_cmd == CMD_REFRESH) ref_cnt <= ref_cnt + 1'b1;
                    cur_cmd <= go_cmd;
                    if (go_cmd == CMD_NORMAL) phase <= PH_NORMAL;
                    else if (pop_q != '0) begin
                        phase   <= PH_ISSUE;
                        pending <= pop_q;
                    end else phase <= PH_WAIT;
                end
                PH_ISSUE: begin
                    pending <= pending & ~pick;
                    if (last_row) phase <= PH_WAIT;
                end
                PH_NORMAL: begin
                    phase     <= PH_DONE;
                    refresh_q <= 1'b1;
                end
                default: phase <= PH_DONE;
            endcase
        end
    end

    // Drive the command interface from the issue phase.
    always_comb begin
        cs_n                 = '1;
        {ras_n, cas_n, we_n} = 3'b111;
        mode_addr            = '0;
        if (phase == PH_ISSUE) begin
            cs_n                 = ~pick;
            {ras_n, cas_n, we_n} = cmd_pins(cur_cmd);
            if (cur_cmd == CMD_MRS)
                mode_addr = {5'b0, 1'b0, cl3_q ? 3'd3 : 3'd2, BURST_INTL, BURST_LEN};
        end
    end

    assign cmd_sel    = cur_cmd;
    assign busy       = phase != PH_IDLE && phase != PH_DONE;
    assign done       = phase == PH_DONE;
    assign refresh_en = refresh_q;

    assert_cmd_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sel <= 3'd4);
    assert_one_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    assert_pop_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cs_n) & ~pop_q) == '0);
    assert_idle_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == '1) |-> ({ras_n, cas_n, we_n} == 3'b111));
    assert_mode_cl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1 && cmd_sel == 3'd3) |-> (mode_addr[6:4] == 3'd2 || mode_addr[6:4] == 3'd3));
    assert_refresh_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_en) |-> $past(cmd_sel) == 3'd0);
    assert_refresh_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !refresh_en);
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

// File: tb/sim_sdram_init_seq.sv
// Bench: a table of row patterns walked by one loop, then directed checks.
module sim_sdram_init_seq;
    localparam int NR = 8, BW = 8, MHZ = 1, SUS = 20, TRP = 3, TRC = 5, TMRD = 2, RR = 8;
    localparam int TPWR = SUS * MHZ;
    localparam int NSC = 4;
    localparam logic [63:0] SC_BOUND [NSC] = '{64'h0807060504030201, 64'h0C0C0C0808080404,
                                               64'h0000000000000000, 64'h0706060606030500};
    localparam logic [7:0]  SC_MASK  [NSC] = '{8'hFF, 8'h25, 8'h00, 8'h8A};
    localparam logic        SC_CL3   [NSC] = '{1'b1, 1'b0, 1'b1, 1'b0};

    logic clk = 0, rst_n = 0, start = 0, cl3_sel = 0;
    logic [63:0] row_bound = '0;
    logic [2:0]  cmd_sel;
    logic [7:0]  cs_n;
    logic        ras_n, cas_n, we_n, busy, refresh_en, done;
    logic [11:0] mode_addr;
    int checks = 0, fails = 0;
    int exp_cyc [128];
    int exp_cmd [128];
    int exp_row [128];

    always #5 clk = ~clk;

    sdram_init_seq #(.NUM_ROWS(NR), .BOUND_W(BW), .CLK_MHZ(MHZ), .STABLE_US(SUS),
        .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .REFRESH_ROUNDS(RR)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cl3_sel(cl3_sel), .row_bound(row_bound),
        .cmd_sel(cmd_sel), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .mode_addr(mode_addr), .busy(busy), .refresh_en(refresh_en), .done(done));

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [2:0] pins_of(int c);
        case (c)
            1: return 3'b111;
            2: return 3'b010;
            4: return 3'b001;
            3: return 3'b000;
            default: return 3'b111;
        endcase
    endfunction

    function automatic int wait_of(int c);
        case (c)
            1: return TPWR;
            2: return TRP;
            4: return TRC;
            default: return TMRD;
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < NSC; s++) begin
            int n, t, idx, last_cyc;
            bit refr_early, bad_code;
            do_reset();
            // R10 reset state
            check(done == 0 && refresh_en == 0 && busy == 0 && cmd_sel == 0 && cs_n == 8'hFF,
                  "R10 reset", {done, refresh_en, busy, cmd_sel, cs_n}, {3'b0, 3'd0, 8'hFF});
            // Expected schedule from the requirements (R2, R3, R4, R11)
            n = 0;
            t = TPWR;
            for (int k = 0; k < 3 + RR; k++) begin
                int c;
                c = (k == 0) ? 1 : (k == 1) ? 2 : (k < 2 + RR) ? 4 : 3;
                for (int r = 0; r < NR; r++) begin
                    if (SC_MASK[s][r]) begin
                        exp_cyc[n] = t; exp_cmd[n] = c; exp_row[n] = r;
                        n++; t++;
                    end
                end
                t += wait_of(c);
            end
            row_bound = SC_BOUND[s];
            cl3_sel   = SC_CL3[s];
            start = 1;
            @(negedge clk);
            start = 0;
            row_bound = '1;
            cl3_sel = ~SC_CL3[s];
            idx = 0; refr_early = 0; bad_code = 0; last_cyc = t + 1;
            for (int c = 0; c <= last_cyc; c++) begin
                if (s == 1 && c == 40) start = 1;   // R9 start while busy
                if (s == 1 && c == 41) start = 0;
                if (cmd_sel > 3'd4) bad_code = 1;
                if (c < t + 1 && refresh_en) refr_early = 1;
                if (cs_n != 8'hFF) begin
                    if (idx < n) begin
                        check(c == exp_cyc[idx] && cs_n == ~(8'h1 << exp_row[idx]),
                              "R4 row/cycle", {c, cs_n}, {exp_cyc[idx], ~(8'h1 << exp_row[idx])});
                        check({ras_n, cas_n, we_n} == pins_of(exp_cmd[idx]) && cmd_sel == exp_cmd[idx],
                              "R6 pins R1 code", {cmd_sel, ras_n, cas_n, we_n},
                              {exp_cmd[idx][2:0], pins_of(exp_cmd[idx])});
                        if (exp_cmd[idx] == 3)
                            check(mode_addr == (SC_CL3[s] ? 12'h03A : 12'h02A), "R7 mode word",
                                  mode_addr, SC_CL3[s] ? 12'h03A : 12'h02A);
                    end else check(0, "R5 extra command", cs_n, 8'hFF);
                    idx++;
                end
                if (c == t)
                    check(cmd_sel == 0 && refresh_en == 0 && done == 0, "R8 normal before refresh",
                          {cmd_sel, refresh_en, done}, 0);
                if (c == t + 1)
                    check(done == 1 && refresh_en == 1, "R8 refresh on at end R2 timing",
                          {done, refresh_en}, 2'b11);
                @(negedge clk);
            end
            check(idx == n, "R3 R11 command count", idx, n);
            check(!refr_early, "R8 refresh early", refr_early, 0);
            check(!bad_code, "R1 reserved code", bad_code, 0);
        end
        // R9: start after done is ignored and done holds
        start = 1;
        @(negedge clk);
        start = 0;
        begin
            bit act;
            act = 0;
            for (int c = 0; c < 30; c++) begin
                if (cs_n != 8'hFF || !done || busy) act = 1;
                @(negedge clk);
            end
            check(!act, "R9 start after done", act, 0);
        end
        // R10: reset clears done
        do_reset();
        check(done == 0 && refresh_en == 0 && cmd_sel == 0, "R10 reset clears",
              {done, refresh_en, cmd_sel}, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule